// File: doc/BRIEF.md
# Double-Buffered Byte-to-Word Serializer

This block gathers a wide data item from a host port one byte per write strobe and hands it to a narrower consumer as a sequence of M-bit words. It has two wide registers. A staging register fills byte by byte. An offload register feeds the consumer. Once an item is complete in staging, it is copied whole into the offload register. Words then leave from the low end of that register, one per accepted handshake.

Because the two registers are separate, the host can load the next item while the previous one is still being sent. The consumer side uses a valid/ready handshake, and a stalled consumer freezes the word being shown. If the host completes an item while the offload register is still busy, the copy waits. During that wait the write port reports busy and ignores further strobes.

Top module: `byte_word_serializer`

## Requirements
- R1: Each accepted write shifts its byte into the bottom of the staging register, moving older bytes up. The first byte of an item therefore ends in the top byte. Words are sent lowest first: word k is bits k*M+M-1 down to k*M of the item.
- R2: After W/8 accepted writes the item is complete. `wr_busy` is high in the cycle that follows the edge of the last write, and it stays high until the item is copied.
- R3: The copy happens on the first edge at which the offload register is empty, or at which its final word is being accepted. The copy has priority over shifting. When the register is empty, `out_valid` is high and `wr_busy` is low in the cycle after the copy edge.
- R4: `out_data` always comes straight from the flops holding the low M bits of the offload register. Each accepted word shifts that register right by M bits.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` unchanged.
- R6: An item provides exactly W/M accepted words, with no gap in `out_valid` between them. `out_valid` drops after the final word is accepted, unless a staged item is copied on that same edge. In that case `out_valid` stays high.
- R7: A new item can be written into staging while the previous item is still being offloaded. The word on the consumer side is not disturbed by this.
- R8: Write strobes that arrive while `wr_busy` is high are ignored. They leave the staged item unchanged.
- R9: A synchronous active-high reset clears both registers, the item-complete flag, both counters and `out_valid`. A partly written item is discarded.
- R10: W must be a multiple of 8 and of M. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_byte | input | 8 | Host byte |
| wr_busy | output | 1 | Complete item waiting for copy; writes ignored |
| out_valid | output | 1 | A word is offered to the consumer |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_data | output | M | Offered word |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the stalled word is held unchanged (R5);
- the copy happens immediately when the offload register is empty (R3);
- `out_valid` drops after the final word when nothing is waiting (R6);
- `wr_busy` persists while the consumer stalls (R8);
- the state after reset is clean (R9).

Other behaviours only the bench's scenarios can show:
- byte order and word order (R1);
- the number of words in each item (R6);
- the continuous `out_valid` from one item into the next (R6);
- that ignored writes leave the staged data intact (R8);
- that a partly written item is discarded by reset (R9).

// File: rtl/bws_pkg.sv
package bws_pkg;
   typedef enum logic [1:0] {
      OFF_KEEP  = 2'd0,
      OFF_SHIFT = 2'd1,
      OFF_LOAD  = 2'd2
   } off_act_e;

   function automatic int cnt_w(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/bws_stager.sv
module bws_stager #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [7:0]   wr_byte,
   input  logic         taken,
   output logic [W-1:0] stage_q,
   output logic         full_q
);
   localparam int NB = W / 8;
   localparam int BCW = bws_pkg::cnt_w(NB);

   logic [BCW-1:0] cnt_q;
   logic [W-1:0]   stage_nx;
   logic           take;

   assign take = wr_en && !full_q;

   generate
      if (NB == 1) begin : g_one_byte
         assign stage_nx = wr_byte;
      end else begin : g_multi_byte
         assign stage_nx = {stage_q[W-9:0], wr_byte};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
         cnt_q   <= '0;
         full_q  <= 1'b0;
      end else begin
         if (take) begin
            stage_q <= stage_nx;
            if (cnt_q == BCW'(NB - 1)) begin
               cnt_q  <= '0;
               full_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + BCW'(1);
            end
         end
         if (taken) full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bws_offloader.sv
module bws_offloader #(
   parameter int W = 32,
   parameter int M = 16
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                pending,
   input  logic [W-1:0]                        load_data,
   input  logic                                out_ready,
   output logic                                taken,
   output logic                                out_valid,
   output logic [M-1:0]                        out_data,
   output logic [bws_pkg::cnt_w(W/M)-1:0]      words_left
);
   import bws_pkg::*;
   localparam int NW = W / M;
   localparam int WCW = cnt_w(NW);

   logic [W-1:0]   off_q;
   logic [W-1:0]   off_shift;
   logic [WCW-1:0] left_q;
   logic           accept;
   off_act_e       act;

   assign out_valid  = (left_q != '0);
   assign accept     = out_valid && out_ready;
   assign out_data   = off_q[M-1:0];
   assign words_left = left_q;
   assign taken      = pending &&
                       ((left_q == '0) || ((left_q == WCW'(1)) && out_ready));

   generate
      if (NW == 1) begin : g_single_word
         assign off_shift = '0;
      end else begin : g_multi_word
         assign off_shift = {{M{1'b0}}, off_q[W-1:M]};
      end
   endgenerate

   always_comb begin
      if (taken)       act = OFF_LOAD;
      else if (accept) act = OFF_SHIFT;
      else             act = OFF_KEEP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         off_q  <= '0;
         left_q <= '0;
      end else begin
         case (act)
            OFF_LOAD: begin
               off_q  <= load_data;
               left_q <= WCW'(NW);
            end
            OFF_SHIFT: begin
               off_q  <= off_shift;
               left_q <= left_q - WCW'(1);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/byte_word_serializer.sv
module byte_word_serializer #(
   parameter int W = 32,
   parameter int M = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [7:0]   wr_byte,
   output logic         wr_busy,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [M-1:0] out_data
);
   localparam int NW = W / M;
   localparam int WCW = bws_pkg::cnt_w(NW);

   // R10: parameter legality
   initial begin
      if (M < 1 || W < 8 || (W % 8) != 0 || (W % M) != 0)
         $fatal(1, "byte_word_serializer: W must be a multiple of 8 and of M");
   end

   logic [W-1:0]   stage_q;
   logic           full_q;
   logic           taken;
   logic [WCW-1:0] words_left;

   bws_stager #(.W(W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_byte (wr_byte),
      .taken   (taken),
      .stage_q (stage_q),
      .full_q  (full_q)
   );

   bws_offloader #(.W(W), .M(M)) u_off (
      .clk        (clk),
      .rst        (rst),
      .pending    (full_q),
      .load_data  (stage_q),
      .out_ready  (out_ready),
      .taken      (taken),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .words_left (words_left)
   );

   assign wr_busy = full_q;
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
   parameter int M   = 16,
   parameter int WCW = 2
) (
   input logic           clk,
   input logic           rst,
   input logic           wr_busy,
   input logic           out_valid,
   input logic           out_ready,
   input logic [M-1:0]   out_data,
   input logic [WCW-1:0] words_left
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5

   AST_COPY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      wr_busy && !out_valid |=> out_valid && !wr_busy); // R3

   AST_LAST_WORD_DROP: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && (words_left == WCW'(1)) && !wr_busy |=> !out_valid); // R6

   AST_BUSY_STICKS: assert property (@(posedge clk) disable iff (rst)
      wr_busy && out_valid && !out_ready |=> wr_busy); // R8

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> !out_valid && !wr_busy); // R9
endmodule

bind byte_word_serializer bws_chk #(.M(M), .WCW(WCW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_busy    (wr_busy),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .words_left (words_left)
);

// File: tb/tb_byte_word_serializer.sv
`timescale 1ns/1ps
module tb_byte_word_serializer;
   localparam int W = 32;
   localparam int M = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [7:0]   wr_byte = '0;
   logic         wr_busy;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [M-1:0] out_data;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   byte_word_serializer #(.W(W), .M(M)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
      .wr_busy(wr_busy), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   // {item[31:0], stall mask[7:0]}: mask bit c set => ready low in consumer cycle c
   localparam logic [39:0] VEC [5] = '{
      {32'h1122_3344, 8'h00},
      {32'hA5C3_0F81, 8'h05},
      {32'hFFFF_0000, 8'h3C},
      {32'h0000_FFFF, 8'hAA},
      {32'hDEAD_BEEF, 8'h13}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      wr_en = 1'b1;
      wr_byte = b;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // R1: first byte written lands in the top byte
   task automatic put_item(input logic [31:0] x);
      for (int i = 0; i < 4; i++) put(x[31-8*i -: 8]);
   endtask

   // collect n words; exp holds word k at bits 16k+15:16k
   task automatic collect(input logic [63:0] exp, input int n, input logic [7:0] mask);
      int got = 0;
      int cyc = 0;
      int gaps = 0;
      bit prev_stall = 0;
      logic [M-1:0] held = '0;
      while (got < n && cyc < 40) begin
         out_ready = !(cyc < 8 && mask[cyc]);
         @(negedge clk);
         if (prev_stall)
            chk(out_valid && out_data == held, "R5 stall hold", {47'd0, out_valid, out_data}, {47'd0, 1'b1, held});
         if (!out_valid) gaps++;
         if (out_valid && out_ready) begin
            chk(out_data == exp[16*got +: 16], "R1/R4 word value", 64'(out_data), 64'(exp[16*got +: 16]));
            got++;
         end
         prev_stall = out_valid && !out_ready;
         held = out_data;
         @(posedge clk); #1;
         cyc++;
      end
      out_ready = 1'b0;
      chk(got == n, "R6 word count", 64'(got), 64'(n));
      chk(gaps == 0, "R6 no valid gap", 64'(gaps), 64'd0);
      @(negedge clk);
      chk(!out_valid, "R6 valid drops after last word", 64'(out_valid), 64'd0);
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin : main
      logic [31:0] a;
      logic [31:0] b;
      do_reset();
      @(negedge clk);
      chk(!out_valid, "R9 reset valid", 64'(out_valid), 64'd0);
      chk(!wr_busy, "R9 reset busy", 64'(wr_busy), 64'd0);
      chk(out_data == '0, "R9 reset data", 64'(out_data), 64'd0);
      @(posedge clk); #1;

      foreach (VEC[v]) begin
         put_item(VEC[v][39:8]);
         @(negedge clk);
         chk(wr_busy && !out_valid, "R2 busy after last byte", {62'd0, wr_busy, out_valid}, 64'd2);
         @(posedge clk); #1;
         @(negedge clk);
         chk(out_valid && !wr_busy, "R3 copy when idle", {62'd0, out_valid, wr_busy}, 64'd2);
         @(posedge clk); #1;
         collect({32'd0, VEC[v][39:8]}, 2, VEC[v][7:0]);
      end

      // R7/R8: load next item while the previous is offloading; writes during busy ignored
      a = 32'h0102_0304;
      b = 32'h5566_7788;
      put_item(a);
      repeat (2) @(posedge clk);
      #1;
      put_item(b);
      @(negedge clk);
      chk(wr_busy, "R8 busy while offload full", 64'(wr_busy), 64'd1);
      chk(out_valid && out_data == a[15:0], "R7 current word undisturbed", 64'(out_data), 64'(a[15:0]));
      @(posedge clk); #1;
      put(8'hEE);
      put(8'h99);
      @(negedge clk);
      chk(wr_busy, "R8 still busy", 64'(wr_busy), 64'd1);
      @(posedge clk); #1;
      collect({b, a}, 4, 8'h02);

      // R9: partial item discarded by reset
      put(8'h77);
      put(8'h66);
      do_reset();
      put_item(32'hCAFE_1234);
      @(negedge clk);
      chk(wr_busy, "R9 fresh item after reset", 64'(wr_busy), 64'd1);
      @(posedge clk); #1;
      collect({32'd0, 32'hCAFE_1234}, 2, 8'h00);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule